// File: doc/BRIEF.md
# Gated Multi-Source Frequency Counter

This block measures the frequency of one of three oscillator outputs: the RF oscillator, the IF oscillator and the stereo decoder clock. It counts the rising edges of the selected source during a gate window that the host opens and closes through register writes. The selected source passes through a two-flop synchroniser and a rising-edge detector, then a power-of-four prescaler, and then reaches a saturating up-counter. The host converts the count to a frequency by dividing by the window length and multiplying by the prescale ratio.

A measurement runs in this order. The host picks the source, keeps the counter-select bit low and sets the measurement-enable bit. It pulses the clear bit, raises enable, waits for the window, drops enable and then reads the count byte by byte. The register slave has a single-cycle write strobe and a combinational read path.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, every register reads 0x00 and the count is zero.
- R2: In the source register at address 0x02, bit 0 selects the IF input, bit 1 the RF input and bit 2 the stereo decoder input. Only edges of the selected input are counted.
- R3: When the source register has no bit set, or more than one bit set, no edges are counted.
- R4: The control register is at address 0x06. Its prescale code in bits 6:4 divides the edge count by 2^(2*code+1), which gives 2, 8, 32, 128, 512, 2048, 8192 and 32768. Every Nth synchronised rising edge increments the count by one.
- R5: While the enable bit (control bit 2) is low, the count and the prescaler residue hold their values, whatever the source does.
- R6: While the clear bit (control bit 7) is high, the count and the prescaler residue are forced to zero, whatever the state of enable.
- R7: Counting needs the measurement-enable bit, which is bit 7 of address 0x12. While this bit is low, the count holds.
- R8: Counting needs the counter-select bit (control bit 1) to be low. While this bit is high, the count holds.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.
- R10: Address 0x0B returns the upper byte of the count and address 0x0A returns the lower byte, zero-extended to 16 bits. The control register reads back all 8 bits. Address 0x02 reads back bits 2:0, address 0x12 reads back bit 7, and other bits and unmapped addresses read as 0.
- R11: Writes to the count addresses 0x0A and 0x0B do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_if_i | input | 1 | IF oscillator output |
| src_rf_i | input | 1 | RF oscillator output |
| src_sd_i | input | 1 | Stereo decoder clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |

## Verification
The bench builds the block with CNT_W set to 10. With that width, saturation at 1023 is reached after about two thousand source edges at prescale code 0, which keeps the run short. Each upper-byte read then exercises the zero extension above bit 9. Prescale code 5 is checked with a count of a few units. Code 7 is checked as a window too short to produce a single tick. Random runs cover codes 0 to 3 on all three sources. Directed runs cover enable hold with a carried residue, clear while disabled, the gating bits and invalid source selections.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_SRC  = 5'h02;
  localparam logic [ADDR_W-1:0] A_CTRL = 5'h06;
  localparam logic [ADDR_W-1:0] A_CLO  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_CHI  = 5'h0B;
  localparam logic [ADDR_W-1:0] A_MEAS = 5'h12;

  localparam int NSRC   = 3;
  localparam int CODE_W = 3;
  localparam int PRE_W  = 15;

  typedef struct packed {
    logic              clr;
    logic [CODE_W-1:0] code;
    logic              swap;
    logic              en;
    logic              csel;
    logic              set;
  } ctrl_t;
endpackage

// File: rtl/fgc_src_sync.sv
module fgc_src_sync
  import fgc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] sel_i,
  output logic            edge_o
);
  logic raw;
  logic [2:0] sh_q;

  // mux only for an exactly one-hot selection
  always_comb begin
    raw = 1'b0;
    if ($countones(sel_i) == 1) raw = |(src_i & sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], raw};
  end

  assign edge_o = sh_q[1] & ~sh_q[2];

  p_edge_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/fgc_prescaler.sv
module fgc_prescaler
  import fgc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             wrap;

  assign lim  = PRE_W'((32'd1 << (2 * int'(code_i) + 1)) - 32'd1);
  assign wrap = pre_q >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i)             pre_q <= '0;
    else if (run_i && edge_i)   pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  assign tick_o = run_i & edge_i & wrap;

  p_pre_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pre_q));
  p_pre_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
endmodule

// File: rtl/fgc_counter.sv
module fgc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
  import fgc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_if_i,
  input  logic              src_rf_i,
  input  logic              src_sd_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic [NSRC-1:0] sel_q;
  ctrl_t           ctrl_q;
  logic            meas_q;
  logic            edge_s;
  logic            tick_s;
  logic            run;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      cnt16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ctrl_q <= '0;
      meas_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_SRC:   sel_q  <= wdata_i[NSRC-1:0];
        A_CTRL:  ctrl_q <= ctrl_t'(wdata_i);
        A_MEAS:  meas_q <= wdata_i[7];
        default: ;
      endcase
    end
  end

  assign run = ctrl_q.en & ~ctrl_q.csel & meas_q;

  fgc_src_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  ({src_sd_i, src_rf_i, src_if_i}),
    .sel_i  (sel_q),
    .edge_o (edge_s)
  );

  fgc_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_s),
    .run_i  (run),
    .clr_i  (ctrl_q.clr),
    .code_i (ctrl_q.code),
    .tick_o (tick_s)
  );

  fgc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_s),
    .clr_i  (ctrl_q.clr),
    .cnt_o  (cnt)
  );

  assign cnt16 = 16'(cnt);

  always_comb begin
    case (addr_i)
      A_SRC:   rdata_o = {5'b0, sel_q};
      A_CTRL:  rdata_o = ctrl_q;
      A_CLO:   rdata_o = cnt16[7:0];
      A_CHI:   rdata_o = cnt16[15:8];
      A_MEAS:  rdata_o = {meas_q, 7'b0};
      default: rdata_o = 8'h00;
    endcase
  end

  p_meas_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_q && !ctrl_q.clr) |=> $stable(cnt));
  p_csel_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.csel && !ctrl_q.clr) |=> $stable(cnt));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !ctrl_q.clr) |=> $stable(cnt));
  p_bad_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(sel_q) != 1 && $past($countones(sel_q) != 1)
     && $past($countones(sel_q) != 1, 2)) |-> !edge_s);
endmodule

// File: tb/sim_freq_gate_counter.sv
module sim_freq_gate_counter;
  localparam int CW   = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src = 3'b000;
  logic       wr = 1'b0;
  logic [4:0] addr = 5'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  freq_gate_counter #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .src_if_i(src[0]), .src_rf_i(src[1]), .src_sd_i(src[2]),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic int exp_cnt(int edges, int code);
    int v = edges >> (2 * code + 1);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wreg(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [4:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic rcount(output int v);
    int hi, lo;
    rreg(5'h0B, hi);
    rreg(5'h0A, lo);
    v = hi * 256 + lo;
  endtask

  task automatic pulses(logic [2:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src = src | mask;
      @(negedge clk);
      @(negedge clk); src = src & ~mask;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  // control byte: clr bit7, code 6:4, en bit2, csel bit1
  task automatic measure(logic [2:0] sel, int code, int n, logic [2:0] mask,
                         logic csel, output int got);
    logic [7:0] base;
    base = {1'b0, 3'(code), 2'b00, csel, 1'b0};
    wreg(5'h02, {5'b0, sel});
    repeat (4) @(negedge clk);
    wreg(5'h06, base | 8'h80);
    wreg(5'h06, base);
    wreg(5'h06, base | 8'h04);
    pulses(mask, n);
    wreg(5'h06, base);
    rcount(got);
  endtask

  initial begin
    int v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(5'h02, v); check("R1 src", v, 0);
    rreg(5'h06, v); check("R1 ctrl", v, 0);
    rreg(5'h12, v); check("R1 meas", v, 0);
    rcount(v);      check("R1 count", v, 0);

    // R7 measurement enable off
    measure(3'b001, 0, 30, 3'b001, 1'b0, v); check("R7 meas off", v, 0);
    wreg(5'h12, 8'h80);

    // R2 mapping and isolation
    measure(3'b001, 0, 40, 3'b110, 1'b0, v); check("R2 if isolated", v, 0);
    measure(3'b001, 0, 40, 3'b001, 1'b0, v); check("R2 if", v, 20);
    measure(3'b010, 1, 40, 3'b010, 1'b0, v); check("R2 rf", v, 5);
    measure(3'b100, 2, 70, 3'b100, 1'b0, v); check("R2 sd", v, 2);
    measure(3'b010, 0, 30, 3'b101, 1'b0, v); check("R2 rf isolated", v, 0);

    // R3 invalid selections
    measure(3'b000, 0, 30, 3'b111, 1'b0, v); check("R3 none", v, 0);
    measure(3'b011, 0, 30, 3'b011, 1'b0, v); check("R3 two", v, 0);

    // R8 counter-select high
    measure(3'b001, 0, 30, 3'b001, 1'b1, v); check("R8 csel", v, 0);

    // R4 random runs
    for (int k = 0; k < 6; k++) begin
      int s, c, n;
      logic [2:0] m;
      s = int'($urandom % 3);
      c = int'($urandom % 4);
      n = 1 + int'($urandom % 300);
      m = 3'(1 << s);
      measure(m, c, n, m, 1'b0, v);
      check("R4 random", v, exp_cnt(n, c));
    end
    measure(3'b001, 5, 4200, 3'b001, 1'b0, v); check("R4 code5", v, exp_cnt(4200, 5));
    measure(3'b010, 7, 1000, 3'b010, 1'b0, v); check("R4 code7", v, 0);

    // R9 saturation
    measure(3'b001, 0, 2100, 3'b001, 1'b0, v); check("R9 sat", v, CMAX);
    rreg(5'h0B, v); check("R10 hi byte", v, CMAX >> 8);
    rreg(5'h0A, v); check("R10 lo byte", v, CMAX & 8'hFF);

    // R5 hold with residue: code 1 (div 8)
    measure(3'b001, 1, 20, 3'b001, 1'b0, v); check("R5 before", v, 2);
    pulses(3'b001, 50);
    rcount(v); check("R5 held", v, 2);
    wreg(5'h06, 8'h14);
    pulses(3'b001, 4);
    rcount(v); check("R5 residue kept", v, 3);
    wreg(5'h06, 8'h10);

    // R11 count writes ignored
    wreg(5'h0A, 8'h55); wreg(5'h0B, 8'h01);
    rcount(v); check("R11 ignored", v, 3);

    // R6 clear while disabled
    wreg(5'h06, 8'h90);
    rcount(v); check("R6 clear", v, 0);
    wreg(5'h06, 8'h94);
    pulses(3'b001, 20);
    rcount(v); check("R6 held at zero", v, 0);
    wreg(5'h06, 8'h00);

    // R10 register readback
    wreg(5'h02, 8'hFF); rreg(5'h02, v); check("R10 src", v, 8'h07);
    wreg(5'h06, 8'h5A); rreg(5'h06, v); check("R10 ctrl", v, 8'h5A);
    wreg(5'h06, 8'h00);
    wreg(5'h12, 8'hFF); rreg(5'h12, v); check("R10 meas", v, 8'h80);
    rreg(5'h1F, v); check("R10 unmapped", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule